// File: doc/BRIEF.md
# Serial SAR Converter Conversion and Frame Control

This block is the digital control core of a small successive-approximation converter with a serial output. A chip-select input, active low, frames each conversion. A serial clock then steps the block through the conversion, the shift-out of the result and the return to acquisition. A stub in place of the comparator and capacitor array presents the finished result as a parallel word. The block latches that word when chip select falls. It then shifts out a fixed 16-position frame on a data output with a separate output enable, so the enable going low stands for high impedance.

The frame is four zero bits, then the result MSB first, then zero padding up to sixteen positions. The `RES_BITS` parameter sets the result width: 10 gives two padding zeros and 8 gives four. The block tracks when conversion finishes and when acquisition of the next sample begins. It classifies an early release of chip select by how many serial-clock falling edges came before it. The outcome is a plain abort, an entry into power-down, or a normal end of frame. A frame flag tells the host when the data of the current frame must be discarded.

Both `sclk` and `cs_n` are sampled on the block clock `clk`, which is assumed to run well above the serial clock. Each edge of either line is acted on in the `clk` cycle in which it is first seen.

Top module: `adc_serial_ctrl`

## Requirements
- R1: A synchronous reset, active high, sets the output enable low and clears the power-down, conversion-in-progress and invalid-frame indications. A frame started after reset carries valid data.
- R2: The output bit changes at chip-select fall and at each serial-clock falling edge, and each frame position is numbered by the falling edges counted so far, with chip-select fall as position 0. Positions 0 to 3 carry zero. Result bit `RES_BITS-1` goes out at position 4 and the LSB at position `3+RES_BITS`. All later positions up to 15 carry zero.
- R3: On the 16th serial-clock falling edge of a frame the output enable goes low, and it stays low until the next chip-select fall.
- R4: When chip select rises, the output enable goes low in the next block clock cycle, whatever position the frame had reached.
- R5: The converting indication rises at chip-select fall and falls on falling edge `RES_BITS+4` (14 for 10-bit, 12 for 8-bit). The acquiring indication rises on the first serial-clock rising edge after falling edge `RES_BITS+3`, and stays high until the next chip-select fall.
- R6: If chip select rises after 2 to 9 serial-clock falling edges of a normal frame, the block enters power-down. After 0, 1, or 10 or more falling edges it does not. While powered down, neither converting nor acquiring is ever high.
- R7: If chip select rises in a normal frame before acquisition has started, the next frame is flagged invalid. If acquisition had started, the next frame is not flagged.
- R8: A frame that starts in power-down is flagged invalid. Power-down clears on that frame's 11th serial-clock falling edge, and a frame ending after only 10 falling edges leaves it set. The frame that follows a wake-up is valid.
- R9: With an 8-bit result, releasing chip select after the 12th falling edge gives a complete 12-position frame. The output enable drops at the release, and the next frame is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Chip select, active low; its fall starts a frame |
| sample_word | input | RES_BITS | Result word from the converter stub |
| sdo_data | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for the data pin; low means high impedance |
| converting | output | 1 | Conversion in progress |
| acquiring | output | 1 | Acquisition phase reached in the current frame |
| powered_down | output | 1 | Block is in power-down |
| frame_invalid | output | 1 | Data of the current frame must be discarded |

## Verification
The bench runs a 10-bit and an 8-bit instance side by side on the same serial lines. It sweeps several result words, including all-ones, all-zeros, alternating patterns and single-bit patterns. Any slip of the MSB position, or padding that is not zero, shows up as a miscompared word.

Early releases are placed on each side of the power-down window: after 1, 2, 9, 10 and 12 edges. A design that counts the chip-select fall as an edge, or that compares with `<` where `<=` is meant, would enter or skip power-down at the wrong count. The 12-edge release separates the two widths. It must flag the next 10-bit frame, which has not reached acquisition, and must not flag the 8-bit one, which has. Dummy frames of 10 and 11 edges probe the wake-up threshold. A design that wakes one edge early, or that fails to flag the wake-up frame, would report the wrong power-down state or pass garbage as valid data.

// File: rtl/adcsc_pkg.sv
package adcsc_pkg;

    localparam int CNT_W       = 5;
    localparam int FRAME_SLOTS = 16;
    localparam int LEAD_ZEROS  = 4;
    localparam int PD_FIRST    = 2;
    localparam int PD_LAST     = 9;
    localparam int WAKE_EDGE   = 11;

    typedef logic [CNT_W-1:0] edge_cnt_t;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
        logic sclk_rise;
    } bus_evt_t;

    // Bit driven at frame position pos for a result of width res held right aligned in word.
    function automatic logic frame_bit(input edge_cnt_t pos, input logic [FRAME_SLOTS-1:0] word,
                                       input int res);
        int p;
        int idx;
        p = int'(pos);
        if (p < LEAD_ZEROS || p >= LEAD_ZEROS + res) begin
            return 1'b0;
        end
        idx = res - 1 - (p - LEAD_ZEROS);
        return word[4'(idx)];
    endfunction

    // True when a chip-select release after cnt falling edges sends the block to power-down.
    function automatic logic in_pd_window(input edge_cnt_t cnt);
        return (int'(cnt) >= PD_FIRST) && (int'(cnt) <= PD_LAST);
    endfunction

endpackage

// File: rtl/adcsc_edge_det.sv
module adcsc_edge_det
    import adcsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    output bus_evt_t evt
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // Serial clock edges count only once chip select has already been low for a sample.
    always_comb begin
        evt.cs_fall   = cs_q & ~cs_n;
        evt.cs_rise   = ~cs_q & cs_n;
        evt.sclk_fall = sclk_q & ~sclk & ~cs_n & ~cs_q;
        evt.sclk_rise = ~sclk_q & sclk & ~cs_n & ~cs_q;
    end
endmodule

// File: rtl/adcsc_edge_ctr.sv
module adcsc_edge_ctr
    import adcsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    output edge_cnt_t cnt,
    output edge_cnt_t fall_num
);
    localparam edge_cnt_t CNT_MAX = '1;

    assign fall_num = (cnt == CNT_MAX) ? cnt : cnt + edge_cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (evt.cs_fall) begin
            cnt <= '0;
        end else if (evt.sclk_fall) begin
            cnt <= fall_num;
        end
    end
endmodule

// File: rtl/adcsc_phase_ctrl.sv
module adcsc_phase_ctrl
    import adcsc_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    input  edge_cnt_t cnt,
    input  edge_cnt_t fall_num,
    output logic      converting,
    output logic      acquiring,
    output logic      powered_down,
    output logic      frame_invalid
);
    localparam edge_cnt_t CONV_END = edge_cnt_t'(RES_BITS + LEAD_ZEROS);
    localparam edge_cnt_t ACQ_EDGE = edge_cnt_t'(RES_BITS + LEAD_ZEROS - 1);
    localparam edge_cnt_t WAKE_AT  = edge_cnt_t'(WAKE_EDGE);

    logic missed_acq;
    logic frame_in_pd;

    always_ff @(posedge clk) begin
        if (rst) begin
            converting    <= 1'b0;
            acquiring     <= 1'b0;
            powered_down  <= 1'b0;
            frame_invalid <= 1'b0;
            missed_acq    <= 1'b0;
            frame_in_pd   <= 1'b0;
        end else begin
            if (evt.cs_fall) begin
                frame_invalid <= powered_down | missed_acq;
                frame_in_pd   <= powered_down;
                converting    <= ~powered_down;
                acquiring     <= 1'b0;
            end
            if (evt.sclk_fall) begin
                if (fall_num == CONV_END) begin
                    converting <= 1'b0;
                end
                if (powered_down && fall_num == WAKE_AT) begin
                    powered_down <= 1'b0;
                end
            end
            if (evt.sclk_rise && !frame_in_pd && !acquiring && cnt >= ACQ_EDGE) begin
                acquiring <= 1'b1;
            end
            if (evt.cs_rise) begin
                converting <= 1'b0;
                if (frame_in_pd) begin
                    missed_acq <= 1'b0;
                end else begin
                    missed_acq <= ~acquiring;
                    if (in_pd_window(cnt)) begin
                        powered_down <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/adcsc_shifter.sv
module adcsc_shifter
    import adcsc_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_evt_t            evt,
    input  edge_cnt_t           fall_num,
    input  logic [RES_BITS-1:0] sample_word,
    output logic                sdo_data,
    output logic                sdo_oe
);
    localparam edge_cnt_t LAST_SLOT = edge_cnt_t'(FRAME_SLOTS);

    logic [FRAME_SLOTS-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            sdo_data <= 1'b0;
            sdo_oe   <= 1'b0;
        end else if (evt.cs_fall) begin
            held     <= FRAME_SLOTS'(sample_word);
            sdo_data <= 1'b0;
            sdo_oe   <= 1'b1;
        end else if (evt.cs_rise) begin
            sdo_data <= 1'b0;
            sdo_oe   <= 1'b0;
        end else if (evt.sclk_fall) begin
            if (fall_num >= LAST_SLOT) begin
                sdo_data <= 1'b0;
                sdo_oe   <= 1'b0;
            end else begin
                sdo_data <= frame_bit(fall_num, held, RES_BITS);
            end
        end
    end
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adcsc_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic [RES_BITS-1:0] sample_word,
    output logic                sdo_data,
    output logic                sdo_oe,
    output logic                converting,
    output logic                acquiring,
    output logic                powered_down,
    output logic                frame_invalid
);
    bus_evt_t  evt;
    edge_cnt_t edge_cnt;
    edge_cnt_t fall_num;

    adcsc_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .evt  (evt)
    );

    adcsc_edge_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cnt      (edge_cnt),
        .fall_num (fall_num)
    );

    adcsc_phase_ctrl #(.RES_BITS(RES_BITS)) u_phase (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .cnt           (edge_cnt),
        .fall_num      (fall_num),
        .converting    (converting),
        .acquiring     (acquiring),
        .powered_down  (powered_down),
        .frame_invalid (frame_invalid)
    );

    adcsc_shifter #(.RES_BITS(RES_BITS)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .fall_num    (fall_num),
        .sample_word (sample_word),
        .sdo_data    (sdo_data),
        .sdo_oe      (sdo_oe)
    );
endmodule

// File: rtl/adcsc_checker.sv
module adcsc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sdo_data,
    input logic       sdo_oe,
    input logic       converting,
    input logic       acquiring,
    input logic       powered_down,
    input logic       frame_invalid,
    input logic [4:0] cnt
);
    AST_LEAD_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && cnt < 5'd4) |-> !sdo_data); // R2

    AST_OE_OFF_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 5'd16) |-> !sdo_oe); // R3

    AST_OE_OFF_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !$past(cs_n)) |=> !sdo_oe); // R4

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        powered_down |-> (!converting && !acquiring)); // R6

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !(!cs_n && $past(cs_n)) |=> $stable(frame_invalid)); // R7

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sdo_oe); // R4
endmodule

bind adc_serial_ctrl adcsc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .sdo_data      (sdo_data),
    .sdo_oe        (sdo_oe),
    .converting    (converting),
    .acquiring     (acquiring),
    .powered_down  (powered_down),
    .frame_invalid (frame_invalid),
    .cnt           (edge_cnt)
);

// File: tb/tb_adc_serial_ctrl.sv
`timescale 1ns/1ps
module tb_adc_serial_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic [9:0] word10 = '0;
    logic [7:0] word8 = '0;
    logic sdo10, oe10, conv10, acq10, pd10, inv10;
    logic sdo8, oe8, conv8, acq8, pd8, inv8;
    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] cap10, cap8;
    logic oe16_10, oe16_8;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    adc_serial_ctrl #(.RES_BITS(10)) dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sample_word(word10),
        .sdo_data(sdo10), .sdo_oe(oe10), .converting(conv10), .acquiring(acq10),
        .powered_down(pd10), .frame_invalid(inv10)
    );

    adc_serial_ctrl #(.RES_BITS(8)) dut8 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sample_word(word8),
        .sdo_data(sdo8), .sdo_oe(oe8), .converting(conv8), .acquiring(acq8),
        .powered_down(pd8), .frame_invalid(inv8)
    );

    localparam logic [9:0] VEC [8] = '{10'h3FF, 10'h000, 10'h2AA, 10'h155,
                                       10'h200, 10'h001, 10'h2C5, 10'h13B};

    function automatic logic [15:0] exp_frame(input int res, input logic [9:0] w);
        logic [15:0] f;
        f = '0;
        for (int pos = 0; pos < 16; pos++) begin
            if (pos >= 4 && pos < 4 + res) f[15-pos] = w[res-1-(pos-4)];
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic s);
        cs_n = c;
        sclk = s;
        @(negedge clk);
    endtask

    // One frame: chip-select fall, nfalls serial-clock pulses, chip-select rise.
    task automatic frame(input int nfalls);
        cap10 = '0;
        cap8 = '0;
        oe16_10 = 1'b1;
        oe16_8 = 1'b1;
        drive(1'b0, 1'b1);
        cap10[15] = sdo10;
        cap8[15] = sdo8;
        for (int i = 1; i <= nfalls; i++) begin
            drive(1'b0, 1'b0);
            if (i < 16) begin
                cap10[15-i] = sdo10;
                cap8[15-i] = sdo8;
            end
            if (i == 16) begin
                oe16_10 = oe10;
                oe16_8 = oe8;
            end
            drive(1'b0, 1'b1);
        end
        drive(1'b1, 1'b1);
    endtask

    task automatic print_summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", {31'd0, oe10}, 0);
        check("R1 pd", {31'd0, pd10 | pd8}, 0);
        check("R1 inv", {31'd0, inv10 | inv8}, 0);
        check("R1 conv", {31'd0, conv10 | conv8}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2/R3 table walk on both widths
        for (int v = 0; v < 8; v++) begin
            word10 = VEC[v];
            word8 = VEC[v][7:0];
            frame(16);
            check("R2 word10", {16'd0, cap10}, {16'd0, exp_frame(10, VEC[v])});
            check("R2 word8", {16'd0, cap8}, {16'd0, exp_frame(8, {2'b00, VEC[v][7:0]})});
            check("R3 oe after 16th", {30'd0, oe16_10, oe16_8}, 0);
            check("R1 valid frame", {30'd0, inv10, inv8}, 0);
        end

        // R5: conversion end and acquisition start per width
        drive(1'b0, 1'b1);
        check("R5 conv at start", {30'd0, conv10, conv8}, 32'd3);
        for (int i = 1; i <= 16; i++) begin
            drive(1'b0, 1'b0);
            if (i == 13) check("R5 conv10 before end", {31'd0, conv10}, 1);
            if (i == 14) check("R5 conv10 ends", {31'd0, conv10}, 0);
            if (i == 11) check("R5 conv8 before end", {31'd0, conv8}, 1);
            if (i == 12) check("R5 conv8 ends", {31'd0, conv8}, 0);
            if (i == 13) check("R5 acq10 not yet", {31'd0, acq10}, 0);
            if (i == 11) check("R5 acq8 not yet", {31'd0, acq8}, 0);
            drive(1'b0, 1'b1);
            if (i == 12) check("R5 acq10 still off", {31'd0, acq10}, 0);
            if (i == 13) check("R5 acq10 on", {31'd0, acq10}, 1);
            if (i == 11) check("R5 acq8 on", {31'd0, acq8}, 1);
        end
        drive(1'b1, 1'b1);

        // R4/R7/R9: release after 12 edges
        word10 = 10'h2C5;
        word8 = 8'hB6;
        cap10 = '0;
        drive(1'b0, 1'b1);
        cap8 = '0;
        cap8[15] = sdo8;
        for (int i = 1; i <= 12; i++) begin
            drive(1'b0, 1'b0);
            cap8[15-i] = sdo8;
            drive(1'b0, 1'b1);
        end
        check("R4 oe before release", {30'd0, oe10, oe8}, 32'd3);
        drive(1'b1, 1'b1);
        check("R4 oe after release", {30'd0, oe10, oe8}, 0);
        check("R9 short frame data", {16'd0, cap8}, {16'd0, exp_frame(8, {2'b00, 8'hB6})});
        check("R6 no pd at 12", {30'd0, pd10, pd8}, 0);
        frame(16);
        check("R7 flag after abort", {31'd0, inv10}, 1);
        check("R9 8-bit next valid", {31'd0, inv8}, 0);
        frame(16);
        check("R7 flag cleared", {31'd0, inv10}, 0);
        check("R2 word10 after abort", {16'd0, cap10}, {16'd0, exp_frame(10, 10'h2C5)});

        // R6: power-down window boundaries
        frame(1);
        check("R6 no pd at 1", {30'd0, pd10, pd8}, 0);
        frame(16);
        check("R7 flag after 1-edge release", {30'd0, inv10, inv8}, 32'd3);
        frame(10);
        check("R6 no pd at 10", {30'd0, pd10, pd8}, 0);
        frame(16);
        frame(2);
        check("R6 pd at 2", {30'd0, pd10, pd8}, 32'd3);

        // R8: wake-up threshold
        frame(10);
        check("R8 still pd after 10", {30'd0, pd10, pd8}, 32'd3);
        check("R8 pd frame flagged", {30'd0, inv10, inv8}, 32'd3);
        check("R6 no conv in pd", {30'd0, conv10, conv8}, 0);
        frame(11);
        check("R8 awake after 11", {30'd0, pd10, pd8}, 0);
        check("R8 wake frame flagged", {30'd0, inv10, inv8}, 32'd3);
        word10 = 10'h13B;
        word8 = 8'h5C;
        frame(16);
        check("R8 next frame valid", {30'd0, inv10, inv8}, 0);
        check("R8 data after wake", {16'd0, cap10}, {16'd0, exp_frame(10, 10'h13B)});
        check("R8 data8 after wake", {16'd0, cap8}, {16'd0, exp_frame(8, {2'b00, 8'h5C})});

        // R6 upper boundary, then R1 reset out of power-down
        frame(9);
        check("R6 pd at 9", {30'd0, pd10, pd8}, 32'd3);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset clears pd", {30'd0, pd10, pd8}, 0);
        frame(16);
        check("R1 frame after reset valid", {30'd0, inv10, inv8}, 0);
        check("R1 data after reset", {16'd0, cap10}, {16'd0, exp_frame(10, 10'h13B)});

        finished = 1'b1;
        print_summary();
        $finish;
    end
endmodule